// File: doc/BRIEF.md
# NAND Flash Status and Read-Path Output Selector

This block is the device-side output path of a byte-wide NAND flash. It builds an 8-bit status byte from internal flags: current and previous operation failure, array busy, cache busy, cache-mode enable and the write-protect pin. It then decides what the byte-wide I/O bus drives during host read cycles. A status-read command switches the output path to the status byte. The path stays there, showing flag changes as they occur, until some other command byte is decoded. A page-read command switches back to data and rewinds the column pointer to the column most recently loaded. In data mode, each rising edge of the read strobe moves the column pointer forward by one.

The block runs on a core clock. The chip enable and read strobe are assumed to be already synchronized into that clock. Command bytes arrive already decoded, as one-cycle strobes. Page data comes from a small stub that derives a byte from the column pointer. The ready/busy output follows the cache-ready status bit. All outputs are registered, so every output reflects the inputs and state one clock earlier.

Top module: `flash_status_port`

## Requirements
- R1: While `rst_n` is low, at the next clock edge `io_oe` and `io_out` go to 0 and `rb_n` goes to 1. The path returns to data mode, and both the column pointer and the start column go to 0.
- R2: A command strobe with byte 70h selects status mode. Every enabled read cycle then returns the status byte until a command strobe with any other byte selects data mode.
- R3: In status mode, a change of any flag appears on `io_out` at the next clock edge while `ce_n` and `re_n` stay low. No repeated command is needed.
- R4: In the status byte, bit 0 is `fail_cur`. Bit 1 is `fail_prev` when `cache_mode` is 1, and 0 otherwise. Bits 2, 3 and 4 are 0.
- R5: Status bit 6 is 1 when `cache_busy` is 0. Bit 5 is 1 only when both `array_busy` and `cache_busy` are 0. Bit 7 equals `wp_n`, where 0 means protected.
- R6: `rb_n` equals status bit 6 of the previous clock cycle.
- R7: A command strobe with byte 00h sets the column pointer to the start column. This rewind wins over a read-strobe rising edge in the same cycle.
- R8: In data mode, with `ce_n` low, a rising edge of `re_n` (low on the previous clock, high now) adds one to the column pointer, wrapping at 2^COL_W. In status mode the pointer does not move.
- R9: When `ce_n` or `re_n` was high in the previous cycle, `io_oe` is 0 and `io_out` is 0.
- R10: In data mode, an enabled read cycle drives the stub byte. The stub byte is column[7:0] XOR 5Ah, with bit 0 also XORed with the parity of column[11:8].
- R11: A column-load strobe sets both the start column and the column pointer, with priority over a rewind and over an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command byte |
| cmd_byte | input | 8 | Command byte value |
| col_load_valid | input | 1 | Strobe that loads a new start column |
| col_load | input | 12 | Start column value |
| ce_n | input | 1 | Chip enable, active low (synchronized) |
| re_n | input | 1 | Read strobe, active low (synchronized) |
| array_busy | input | 1 | Array operation in progress |
| cache_busy | input | 1 | Cache or data register cannot take data |
| cache_mode | input | 1 | Cache operation selected |
| fail_cur | input | 1 | Current operation failed |
| fail_prev | input | 1 | Previous operation failed |
| wp_n | input | 1 | Write-protect pin, 0 = protected |
| io_out | output | 8 | Byte driven onto the I/O bus |
| io_oe | output | 1 | Output enable, 0 = high impedance |
| rb_n | output | 1 | Ready/busy output, 1 = ready |

## Verification
Two column updates can fall in the same cycle. A read-strobe rising edge can coincide with a page-read command strobe, and a column load can coincide with both. The bench provokes each collision by raising `re_n` in the same cycle that the strobe is asserted. It then judges the outcome through the data byte of the next read cycle, which must come from the rewound or loaded column and not from the advanced one. Because status mode must show live values, the bench also walks all flag patterns while the strobe is held low and compares every cycle.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RD_PAGE   = 8'h00;

    localparam int SB_FAIL_CUR  = 0;
    localparam int SB_FAIL_PREV = 1;
    localparam int SB_ARRAY_RDY = 5;
    localparam int SB_CACHE_RDY = 6;
    localparam int SB_WP_N      = 7;

    typedef enum logic {
        PATH_DATA   = 1'b0,
        PATH_STATUS = 1'b1
    } path_e;

    typedef struct packed {
        logic [7:0] io;
        logic       oe;
        logic       rb_n;
    } out_t;

endpackage

// File: rtl/fsp_status_build.sv
module fsp_status_build
    import fsp_pkg::*;
(
    input  logic       array_busy,
    input  logic       cache_busy,
    input  logic       cache_mode,
    input  logic       fail_cur,
    input  logic       fail_prev,
    input  logic       wp_n,
    output logic [7:0] status_byte
);

    always_comb begin
        status_byte                = '0;
        status_byte[SB_FAIL_CUR]   = fail_cur;
        status_byte[SB_FAIL_PREV]  = cache_mode & fail_prev;
        status_byte[SB_ARRAY_RDY]  = ~(array_busy | cache_busy);
        status_byte[SB_CACHE_RDY]  = ~cache_busy;
        status_byte[SB_WP_N]       = wp_n;
    end

endmodule

// File: rtl/fsp_data_stub.sv
module fsp_data_stub #(
    parameter int         COL_W = 12,
    parameter logic [7:0] SEED  = 8'h5A
) (
    input  logic [COL_W-1:0] col,
    output logic [7:0]       data
);

    generate
        if (COL_W > 8) begin : g_fold
            assign data = col[7:0] ^ SEED ^ {7'b0, ^col[COL_W-1:8]};
        end else begin : g_flat
            assign data = col[7:0] ^ SEED;
        end
    endgenerate

endmodule

// File: rtl/fsp_mode_ctrl.sv
module fsp_mode_ctrl
    import fsp_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             col_load_valid,
    input  logic [COL_W-1:0] col_load,
    input  logic             ce_n,
    input  logic             re_n,
    output path_e            path,
    output logic [COL_W-1:0] col
);

    typedef struct packed {
        path_e            path;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] start;
        logic             re_prev;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{path: PATH_DATA, col: '0, start: '0, re_prev: 1'b1};

    ctrl_t ctrl_d, ctrl_q;
    logic  re_rise;

    always_comb begin
        ctrl_d         = ctrl_q;
        re_rise        = re_n & ~ctrl_q.re_prev & ~ce_n;
        ctrl_d.re_prev = re_n;

        if (col_load_valid) begin
            ctrl_d.start = col_load;
            ctrl_d.col   = col_load;
        end else if (cmd_valid && cmd_byte == CMD_RD_PAGE) begin
            ctrl_d.col = ctrl_q.start;
        end else if (re_rise && ctrl_q.path == PATH_DATA) begin
            ctrl_d.col = ctrl_q.col + 1'b1;
        end

        if (cmd_valid) begin
            ctrl_d.path = (cmd_byte == CMD_RD_STATUS) ? PATH_STATUS : PATH_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    assign path = ctrl_q.path;
    assign col  = ctrl_q.col;

    assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.path == PATH_STATUS && !cmd_valid) |=> ctrl_q.path == PATH_STATUS);

    assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == CMD_RD_PAGE && !col_load_valid) |=> ctrl_q.col == $past(ctrl_q.start));

    assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.path == PATH_STATUS && !cmd_valid && !col_load_valid) |=> $stable(ctrl_q.col));

endmodule

// File: rtl/flash_status_port.sv
module flash_status_port
    import fsp_pkg::*;
#(
    parameter int         COL_W     = 12,
    parameter logic [7:0] STUB_SEED = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             col_load_valid,
    input  logic [COL_W-1:0] col_load,
    input  logic             ce_n,
    input  logic             re_n,
    input  logic             array_busy,
    input  logic             cache_busy,
    input  logic             cache_mode,
    input  logic             fail_cur,
    input  logic             fail_prev,
    input  logic             wp_n,
    output logic [7:0]       io_out,
    output logic             io_oe,
    output logic             rb_n
);

    localparam out_t OUT_RST = '{io: 8'h00, oe: 1'b0, rb_n: 1'b1};

    path_e            path;
    logic [COL_W-1:0] col;
    logic [7:0]       status_byte;
    logic [7:0]       data_byte;
    logic             rd_en;
    out_t             out_d, out_q;

    fsp_mode_ctrl #(.COL_W(COL_W)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_byte       (cmd_byte),
        .col_load_valid (col_load_valid),
        .col_load       (col_load),
        .ce_n           (ce_n),
        .re_n           (re_n),
        .path           (path),
        .col            (col)
    );

    fsp_status_build u_status (
        .array_busy  (array_busy),
        .cache_busy  (cache_busy),
        .cache_mode  (cache_mode),
        .fail_cur    (fail_cur),
        .fail_prev   (fail_prev),
        .wp_n        (wp_n),
        .status_byte (status_byte)
    );

    fsp_data_stub #(.COL_W(COL_W), .SEED(STUB_SEED)) u_stub (
        .col  (col),
        .data (data_byte)
    );

    always_comb begin
        rd_en      = ~ce_n & ~re_n;
        out_d.oe   = rd_en;
        out_d.rb_n = status_byte[SB_CACHE_RDY];
        if (!rd_en)                   out_d.io = 8'h00;
        else if (path == PATH_STATUS) out_d.io = status_byte;
        else                          out_d.io = data_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign io_out = out_q.io;
    assign io_oe  = out_q.oe;
    assign rb_n   = out_q.rb_n;

    assert_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || re_n) |=> (!io_oe && io_out == 8'h00));

    assert_rb_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rb_n == $past(status_byte[SB_CACHE_RDY]));

    assert_status_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && path == PATH_STATUS) |=> io_out == $past(status_byte));

endmodule

// File: tb/flash_status_port_tb.sv
`timescale 1ns/1ps
module flash_status_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        col_load_valid = 1'b0;
    logic [11:0] col_load = '0;
    logic        ce_n = 1'b1, re_n = 1'b1;
    logic        array_busy = 1'b0, cache_busy = 1'b0, cache_mode = 1'b0;
    logic        fail_cur = 1'b0, fail_prev = 1'b0, wp_n = 1'b1;
    logic [7:0]  io_out;
    logic        io_oe, rb_n;

    always #2.5 clk = ~clk;

    flash_status_port u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .col_load_valid(col_load_valid), .col_load(col_load), .ce_n(ce_n), .re_n(re_n),
        .array_busy(array_busy), .cache_busy(cache_busy), .cache_mode(cache_mode),
        .fail_cur(fail_cur), .fail_prev(fail_prev), .wp_n(wp_n),
        .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n)
    );

    // reference model state
    int    m_stat, m_col, m_start, m_reprev;
    int    exp_io, exp_oe, exp_rb;
    int    n_vec = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    function automatic int ref_status();
        int s;
        s = 0;
        if (wp_n)                       s += 128;
        if (!cache_busy)                s += 64;
        if (!array_busy && !cache_busy) s += 32;
        if (cache_mode && fail_prev)    s += 2;
        if (fail_cur)                   s += 1;
        return s;
    endfunction

    function automatic int ref_data(int c);
        int par;
        par = ((c >> 8) & 1) ^ ((c >> 9) & 1) ^ ((c >> 10) & 1) ^ ((c >> 11) & 1);
        return ((c & 255) ^ 90) ^ par;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            exp_io = 0; exp_oe = 0; exp_rb = 1;
            m_stat = 0; m_col = 0; m_start = 0; m_reprev = 1;
        end else begin
            int  s;
            bit  en, rise;
            s    = ref_status();
            en   = !ce_n && !re_n;
            exp_oe = en;
            exp_rb = (s / 64) % 2;
            exp_io = !en ? 0 : (m_stat != 0 ? s : ref_data(m_col));
            rise = re_n && (m_reprev == 0) && !ce_n;
            if (col_load_valid) begin
                m_start = col_load; m_col = col_load;
            end else if (cmd_valid && cmd_byte == 8'h00) begin
                m_col = m_start;
            end else if (rise && m_stat == 0) begin
                m_col = (m_col + 1) % 4096;
            end
            if (cmd_valid) m_stat = (cmd_byte == 8'h70);
            m_reprev = re_n;
        end
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected under 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            n_vec++;
            if (io_out !== exp_io[7:0] || io_oe !== exp_oe[0] || rb_n !== exp_rb[0]) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual io=%02h oe=%0b rb=%0b expected io=%02h oe=%0b rb=%0b",
                         cur_req, cyc, io_out, io_oe, rb_n, exp_io[7:0], exp_oe[0], exp_rb[0]);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic command(logic [7:0] b);
        cmd_byte = b; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
    endtask

    task automatic strobe(int n);
        for (int k = 0; k < n; k++) begin
            re_n = 1'b0; tick(); re_n = 1'b1; tick();
        end
    endtask

    initial begin
        cur_req = "R1";
        tick(3);
        rst_n = 1'b1;
        tick(2);

        cur_req = "R11";
        col_load = 12'd10; col_load_valid = 1'b1; tick(); col_load_valid = 1'b0;
        ce_n = 1'b0; tick();

        cur_req = "R8";   strobe(5);          // pointer moves to 15, R10 bytes compared
        cur_req = "R10";  re_n = 1'b0; tick(3); re_n = 1'b1; tick();
        cur_req = "R7";   command(8'h00);     // back to 10
        strobe(2);
        // collision: rising strobe edge and rewind together
        re_n = 1'b0; tick();
        re_n = 1'b1; cmd_byte = 8'h00; cmd_valid = 1'b1; tick(); cmd_valid = 1'b0;
        re_n = 1'b0; tick(2); re_n = 1'b1; tick();
        cur_req = "R11";  // load collides with rewind and edge
        re_n = 1'b0; tick();
        re_n = 1'b1; cmd_valid = 1'b1; col_load = 12'h3FE; col_load_valid = 1'b1; tick();
        cmd_valid = 1'b0; col_load_valid = 1'b0;
        strobe(4);                            // wrap through 0x400 parity change

        cur_req = "R2";   command(8'h70);
        re_n = 1'b0; tick(2);
        cur_req = "R3";
        for (int i = 0; i < 64; i++) begin
            {array_busy, cache_busy, cache_mode, fail_cur, fail_prev, wp_n} = i[5:0];
            tick();
        end
        cur_req = "R4";   cache_mode = 1'b1; fail_prev = 1'b1; fail_cur = 1'b0; tick(2);
        cache_mode = 1'b0; tick(2);
        cur_req = "R5";   array_busy = 1'b1; cache_busy = 1'b0; wp_n = 1'b0; tick(2);
        cur_req = "R6";   cache_busy = 1'b1; tick(); cache_busy = 1'b0; tick(2);
        re_n = 1'b1; tick();
        cur_req = "R8";   strobe(3);          // status mode: pointer frozen
        cur_req = "R2";   command(8'h80);     // any other command leaves status mode
        strobe(2);
        command(8'h70); strobe(1);
        cur_req = "R7";   command(8'h00); strobe(2);

        cur_req = "R9";   ce_n = 1'b1; re_n = 1'b0; tick(3);
        ce_n = 1'b0; re_n = 1'b1; tick(2);
        cur_req = "R1";   rst_n = 1'b0; re_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
        re_n = 1'b1; tick(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule